// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked monostable. It watches two active-low arming inputs and two active-high arming inputs. When the qualifying edge arrives, it drives a pulse on a complementary output pair (`pulse_o` high, `pulse_no` low). A 16-bit input sets the pulse length in system clock cycles; it takes the place of an external timing network.

Every input passes through a two-stage synchronizer before it is used, so the pins may be fully asynchronous to `clk_i`. A trigger that arrives while a pulse is running reloads the full length, so the pulse always ends exactly that many cycles after the most recent trigger. An active-low clear holds the outputs idle and blocks all triggering for as long as it is asserted.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: A trigger fires when, on the synchronized inputs, both `trig_hi_i` bits are now high, at least one `trig_lo_ni` bit is now low, and on the previous sample not both `trig_hi_i` bits were high.
- R2: A trigger also fires when both `trig_hi_i` bits are high on the current and previous samples, and the `trig_lo_ni` pair goes from both high (2'b11) to at least one bit low.
- R3: Input changes reach the output three clock edges later: two synchronizer stages plus the counter register. After a trigger, `pulse_o` is high and `pulse_no` is low for exactly the programmed number of cycles.
- R4: No pulse starts without a qualifying edge. This covers a trigger condition that holds steady, and `trig_hi_i` reaching 2'b11 while `trig_lo_ni` is 2'b11.
- R5: While the synchronized `clr_ni` is low, the counter is zero, `pulse_o` is 0, `pulse_no` is 1, and arming edges are ignored. A running pulse ends three edges after `clr_ni` falls.
- R6: A trigger during an active pulse reloads the full width, so the pulse ends `width_i` cycles after the last trigger.
- R7: A `width_i` of 0 gives a pulse one cycle long. Any other value N gives N cycles.
- R8: Raising `clr_ni` while the trigger condition is already true starts no pulse. A later qualifying edge still does.
- R9: During and right after reset, `pulse_o` is 0 and `pulse_no` is 1.
- R10: `width_i` is sampled only at the trigger cycle. Changing it during a pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_lo_ni | input | 2 | Active-low arming inputs (falling-edge trigger path) |
| trig_hi_i | input | 2 | Active-high arming inputs (rising-edge trigger path) |
| clr_ni | input | 1 | Active-low clear; forces idle outputs and blocks triggers |
| width_i | input | 16 | Pulse length in clock cycles (0 acts as 1) |
| pulse_o | output | 1 | Pulse output, high while active |
| pulse_no | output | 1 | Complement of `pulse_o` |

## Verification
The arming pins are driven with patterns that separate the two trigger paths from the near misses. These are the active-high pair completing while an active-low pin is already low, an active-low pin falling under a completed high pair, the high pair completing with both low pins still high, and a condition held true for many cycles. Only the first two may produce a pulse. Retrigger, clear-during-pulse, clear release over a true condition, a zero width and a width change mid-pulse each give a distinct pulse length, so a wrong reload, an ungated edge or a late width sample shows up as a length mismatch. A long random run toggles single arming bits, clear and width against a cycle-level bench model, and compares both outputs on every cycle.

// File: rtl/os_pkg.sv
package os_pkg;
  typedef enum logic [1:0] {
    TRIG_NONE    = 2'd0,
    TRIG_HI_RISE = 2'd1,
    TRIG_LO_FALL = 2'd2
  } trig_kind_e;

  localparam int unsigned OS_SYNC_STAGES = 2;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/os_edge_qual.sv
module os_edge_qual
  import os_pkg::*;
#(
  parameter int unsigned N_LO = 2,
  parameter int unsigned N_HI = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [N_LO-1:0] lo_s_i,
  input  logic [N_HI-1:0] hi_s_i,
  output logic            fire_o
);
  logic [N_LO-1:0] lo_prev_q;
  logic [N_HI-1:0] hi_prev_q;
  logic            any_lo_now, any_lo_prev, all_hi_now, all_hi_prev;
  trig_kind_e      kind;

  // history runs regardless of clear so a release cannot fake an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_prev_q <= '0;
      hi_prev_q <= '0;
    end else begin
      lo_prev_q <= lo_s_i;
      hi_prev_q <= hi_s_i;
    end
  end

  assign any_lo_now  = ~&lo_s_i;
  assign any_lo_prev = ~&lo_prev_q;
  assign all_hi_now  = &hi_s_i;
  assign all_hi_prev = &hi_prev_q;

  always_comb begin
    kind = TRIG_NONE;
    if (all_hi_now && any_lo_now) begin
      if (!all_hi_prev)      kind = TRIG_HI_RISE;
      else if (!any_lo_prev) kind = TRIG_LO_FALL;
    end
  end

  assign fire_o = en_i && (kind != TRIG_NONE);
endmodule

// File: rtl/os_timer.sv
module os_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_s_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] width_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, load_val;

  assign load_val = (width_i == '0) ? CNT_ONE : width_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!clr_s_i)        cnt_q <= '0;
    else if (fire_i)          cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_ONE;
  end

  assign cnt_o    = cnt_q;
  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen #(
  parameter int unsigned N_LO  = 2,
  parameter int unsigned N_HI  = 2,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LO-1:0]  trig_lo_ni,
  input  logic [N_HI-1:0]  trig_hi_i,
  input  logic             clr_ni,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o,
  output logic             pulse_no
);
  localparam int unsigned SYNC_W = N_LO + N_HI + 1;

  logic [SYNC_W-1:0] raw_in, sync_out;
  logic [N_LO-1:0]   lo_s;
  logic [N_HI-1:0]   hi_s;
  logic              clr_s, fire, active;
  logic [CNT_W-1:0]  cnt_q;

  assign raw_in = {clr_ni, trig_lo_ni, trig_hi_i};

  os_sync #(.WIDTH(SYNC_W), .STAGES(os_pkg::OS_SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign clr_s = sync_out[SYNC_W-1];
  assign lo_s  = sync_out[N_HI +: N_LO];
  assign hi_s  = sync_out[N_HI-1:0];

  os_edge_qual #(.N_LO(N_LO), .N_HI(N_HI)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (clr_s),
    .lo_s_i(lo_s),
    .hi_s_i(hi_s),
    .fire_o(fire)
  );

  os_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_s_i (clr_s),
    .fire_i  (fire),
    .width_i (width_i),
    .cnt_o   (cnt_q),
    .active_o(active)
  );

  assign pulse_o  = active;
  assign pulse_no = ~active;
endmodule

// File: rtl/os_chk.sv
module os_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_s_i,
  input logic             fire_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] width_i,
  input logic             pulse_i,
  input logic             pulse_n_i
);
  assert_fire_starts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> pulse_i && !pulse_n_i);

  assert_rise_needs_fire_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> $past(fire_i));

  assert_clear_idles_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_s_i |=> !pulse_i && pulse_n_i);

  assert_pulse_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && clr_s_i && cnt_i > CNT_W'(1)) |=> pulse_i);

  assert_reload_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> cnt_i == (($past(width_i) == '0) ? CNT_W'(1) : $past(width_i)));
endmodule

bind oneshot_pulse_gen os_chk #(.CNT_W(CNT_W)) u_os_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_s_i  (clr_s),
  .fire_i   (fire),
  .cnt_i    (cnt_q),
  .width_i  (width_i),
  .pulse_i  (pulse_o),
  .pulse_n_i(pulse_no)
);

// File: tb/oneshot_pulse_gen_tb_top.sv
module oneshot_pulse_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lo_n = 2'b11;
  logic [1:0]  hi = 2'b00;
  logic        clr_n = 1'b1;
  logic [15:0] width = 16'd5;
  logic        pulse_o, pulse_no;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  oneshot_pulse_gen dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .trig_lo_ni(lo_n),
    .trig_hi_i (hi),
    .clr_ni    (clr_n),
    .width_i   (width),
    .pulse_o   (pulse_o),
    .pulse_no  (pulse_no)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench model: {clr, lo[1:0], hi[1:0]} through two samples, then edge + counter
  logic [4:0]  m_s1, m_s2;
  logic        m_cprev;
  logic [15:0] m_cnt;

  function automatic bit cond_f(input logic [4:0] s);
    return (~&s[3:2]) && (&s[1:0]);
  endfunction

  function automatic logic [15:0] eff_w(input logic [15:0] w);
    return (w == 16'd0) ? 16'd1 : w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_cprev <= 1'b0; m_cnt <= '0;
    end else begin
      m_s1    <= {clr_n, lo_n, hi};
      m_s2    <= m_s1;
      m_cprev <= cond_f(m_s2);
      if (!m_s2[4])                          m_cnt <= '0;
      else if (cond_f(m_s2) && !m_cprev)     m_cnt <= eff_w(width);
      else if (m_cnt != 0)                   m_cnt <= m_cnt - 16'd1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 R6 model pulse_o", int'(pulse_o), int'(m_cnt != 0));
      chk("R5 model pulse_no", int'(pulse_no), int'(m_cnt == 0));
    end
  end

  task automatic watch(input int win, output int lat, output int len);
    lat = 0; len = 0;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (pulse_o) begin
        if (lat == 0) lat = i;
        len++;
      end
    end
  endtask

  task automatic arm();
    int l, n;
    lo_n = 2'b11; hi = 2'b00;
    watch(8, l, n);
  endtask

  initial begin
    int lat, len, nlow;
    void'($urandom(32'd20240607));

    repeat (3) @(negedge clk);
    chk("R9 reset pulse_o", int'(pulse_o), 0);
    chk("R9 reset pulse_no", int'(pulse_no), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset pulse_o", int'(pulse_o), 0);
    arm();

    // R1: high pair completes while a low pin is low
    lo_n = 2'b10; hi = 2'b01;
    watch(6, lat, len);
    chk("R4 partial high pair", len, 0);
    hi = 2'b11;
    watch(12, lat, len);
    chk("R1 latency R3", lat, 3);
    chk("R1 length R3", len, 5);

    // R2: low pin falls under completed high pair
    arm();
    hi = 2'b11;
    watch(6, lat, len);
    chk("R4 high pair with low pins idle", len, 0);
    lo_n = 2'b01;
    watch(12, lat, len);
    chk("R2 latency", lat, 3);
    chk("R2 length", len, 5);
    watch(10, lat, len);
    chk("R4 steady condition", len, 0);

    // R7: zero width
    arm();
    width = 16'd0;
    hi = 2'b11; lo_n = 2'b10;
    watch(12, lat, len);
    chk("R7 zero width length", len, 1);

    // R6: retrigger
    width = 16'd10;
    arm();
    hi = 2'b11;
    @(negedge clk);
    lo_n = 2'b01;
    lat = 0; len = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (pulse_o) begin if (lat == 0) lat = i; len++; end
      if (i == 4) lo_n = 2'b11;
      if (i == 5) lo_n = 2'b01;
    end
    chk("R6 retrigger length", len, 15);

    // R5: clear during pulse, edges ignored while low
    width = 16'd20;
    arm();
    hi = 2'b11;
    @(negedge clk);
    lo_n = 2'b01;
    len = 0; nlow = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (pulse_o) len++;
      if (i >= 9 && !pulse_no) nlow++;
      if (i == 6)  clr_n = 1'b0;
      if (i == 10) lo_n = 2'b11;
      if (i == 12) lo_n = 2'b10;
    end
    chk("R5 clear cuts pulse", len, 6);
    chk("R5 pulse_no held high", nlow, 0);

    // R8: release over a true condition
    clr_n = 1'b1;
    watch(12, lat, len);
    chk("R8 release no pulse", len, 0);
    lo_n = 2'b11;
    watch(4, lat, len);
    lo_n = 2'b01;
    watch(30, lat, len);
    chk("R8 later edge fires", len, 20);

    // R10: width change mid-pulse
    width = 16'd8;
    arm();
    hi = 2'b11;
    @(negedge clk);
    lo_n = 2'b10;
    len = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (pulse_o) len++;
      if (i == 5) width = 16'd30;
    end
    chk("R10 width held", len, 8);

    // random: R1 R2 R5 R6 R7 against the model
    width = 16'd4;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) begin
        case ($urandom_range(3))
          0: lo_n[0] = ~lo_n[0];
          1: lo_n[1] = ~lo_n[1];
          2: hi[0]   = ~hi[0];
          default: hi[1] = ~hi[1];
        endcase
      end
      if (clr_n && $urandom_range(299) == 0) clr_n = 1'b0;
      else if (!clr_n && $urandom_range(19) == 0) clr_n = 1'b1;
      if ($urandom_range(49) == 0) width = 16'($urandom_range(12));
    end
    clr_n = 1'b1;
    repeat (40) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    done = 1'b1;
    checks++;
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule